// File: doc/BRIEF.md
# SYSREF-Aligned Multiframe Clock Generator

This block produces the local multiframe boundary strobe for a serial converter link layer. It runs in the link clock domain, which is the lane rate divided by 40. A counter steps through one multiframe, whose length in link-clock cycles is set by a configuration input. The strobe pulses for one cycle each time the counter is at zero. The phase of that counter either runs free or is locked to rising edges of an already registered SYSREF input.

There are three modes. The internal mode ignores SYSREF and runs the counter on its own. The continuous mode checks every SYSREF edge and moves the counter onto any edge that does not land on a boundary. The one-shot mode takes the phase from the first edge and keeps it after that. In both external modes the boundary is withheld, with the valid flag low, until an edge has been captured. Logic that waits for a boundary therefore cannot start on a phase that is about to be replaced.

Two status flags are provided. The capture flag shows that an edge has been taken. A sticky flag records an edge that arrived away from a boundary.

Top module: `mfclk_align`

## Requirements
- R1: An edge is a 0-to-1 change of `sysref_in` between two consecutive link-clock samples. An input held high counts as a single edge.
- R2: The counter runs 0 to `period`-1 and then wraps. `lmfc_strobe` is high in each cycle where the count is 0 and `lmfc_valid` is high. A `period` of 0 or 1 gives a strobe in every cycle.
- R3: `mode_sel` encoding: 0 is internal, 1 is continuous, 2 is one-shot, and 3 behaves exactly like 0.
- R4: In internal mode `lmfc_valid` is high, the counter runs freely, and SYSREF edges change neither the strobe spacing nor `sysref_seen`, which stays 0.
- R5: In an external mode, `lmfc_valid` and `lmfc_strobe` stay low until the first edge. The sample in which that edge is seen is taken as count 0, so the first strobe follows `period` cycles later, and `sysref_seen` goes high.
- R6: In continuous mode, an edge that arrives while the count is not 0 moves the phase: the next strobe comes `period` cycles after that edge.
- R7: In one-shot mode, edges after the first never move the phase.
- R8: `sysref_misaligned` is a sticky flag. It is set by an edge in an external mode after capture while the count is not 0. An edge at count 0 does not set it. `status_clr` clears it, and a set in the same cycle as a clear wins.
- R9: A change of `mode_sel` or a `sync_clr` pulse clears the counter to 0 and clears `sysref_seen`. `sync_clr` also clears `sysref_misaligned`.
- R10: After the asynchronous reset, the count is 0, the mode is internal, and both status flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_clr | input | 1 | Synchronous restart of counter and status |
| mode_sel | input | 2 | SYSREF handling mode |
| period | input | CNT_W | Multiframe length in link-clock cycles |
| sysref_in | input | 1 | Registered SYSREF level |
| status_clr | input | 1 | Clears the misaligned flag |
| lmfc_strobe | output | 1 | One-cycle multiframe boundary pulse |
| lmfc_valid | output | 1 | Boundary phase is established |
| sysref_seen | output | 1 | An edge has been captured since the last restart |
| sysref_misaligned | output | 1 | Sticky flag for an edge off the boundary |

## Verification
The bench builds the block with a 5-bit count width. It switches `period` at run time between 8, 5, 1 and 0, so strobe spacing, the single-cycle case and the zero case are all reached within a few dozen cycles. Because multiframes are this short, edges can be placed on exact counter phases: off-boundary edges realign in continuous mode and are ignored in one-shot mode, and an on-boundary edge leaves the misaligned flag clear.

// File: rtl/mfa_pkg.sv
package mfa_pkg;
  typedef enum logic [1:0] {
    MODE_INT  = 2'd0,
    MODE_CONT = 2'd1,
    MODE_ONCE = 2'd2,
    MODE_RSVD = 2'd3
  } sref_mode_e;
endpackage

// File: rtl/mfa_edge.sv
module mfa_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic sysref_in,
  output logic rise
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sysref_in;
  end

  assign rise = sysref_in & ~prev_q;

  // R1
  edge_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
endmodule

// File: rtl/mfa_counter.sv
module mfa_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] period,
  input  logic             restart,
  input  logic             realign,
  output logic             zero
);
  localparam int EW = CNT_W + 1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [EW-1:0]    inc_w;
  logic             wrap, tiny;

  assign inc_w = {1'b0, cnt_q} + EW'(1);
  assign wrap  = inc_w >= {1'b0, period};
  assign tiny  = {1'b0, period} <= EW'(1);

  always_comb begin
    if (restart)      cnt_d = '0;
    else if (realign) cnt_d = tiny ? '0 : CNT_W'(1);
    else if (wrap)    cnt_d = '0;
    else              cnt_d = inc_w[CNT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign zero = (cnt_q == '0);

  // R9
  restart_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> zero);

  // R2
  tiny_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tiny && $stable(period)) |=> zero);
endmodule

// File: rtl/mfa_track.sv
module mfa_track
  import mfa_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode_sel,
  input  logic       sync_clr,
  input  logic       status_clr,
  input  logic       rise,
  input  logic       cnt_zero,
  output sref_mode_e mode_cur,
  output logic       restart,
  output logic       realign,
  output logic       ext_mode,
  output logic       seen,
  output logic       misaligned
);
  sref_mode_e mode_q;
  logic       seen_q, seen_d, seen_en;
  logic       mis_q, mis_d, mis_en;
  logic       mode_chg, take, bad;

  assign mode_chg = (mode_sel != mode_q);
  assign restart  = sync_clr | mode_chg;
  assign ext_mode = (mode_q == MODE_CONT) || (mode_q == MODE_ONCE);
  assign take     = !restart && rise && ext_mode;
  assign realign  = take && ((mode_q == MODE_CONT) || !seen_q);
  assign bad      = take && seen_q && !cnt_zero;

  always_comb begin
    seen_en = restart | take;
    seen_d  = !restart;
    mis_en  = sync_clr | bad | status_clr;
    if (sync_clr) mis_d = 1'b0;
    else if (bad) mis_d = 1'b1;
    else          mis_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_INT;
      seen_q <= 1'b0;
      mis_q  <= 1'b0;
    end else begin
      if (mode_chg) mode_q <= sref_mode_e'(mode_sel);
      if (seen_en)  seen_q <= seen_d;
      if (mis_en)   mis_q  <= mis_d;
    end
  end

  assign mode_cur   = mode_q;
  assign seen       = seen_q;
  assign misaligned = mis_q;

  // R8
  mis_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(misaligned) |-> $past(rise && seen_q && !cnt_zero));

  // R4
  int_no_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_mode && !mode_chg) |=> !seen);
endmodule

// File: rtl/mfclk_align.sv
module mfclk_align #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sync_clr,
  input  logic [1:0]       mode_sel,
  input  logic [CNT_W-1:0] period,
  input  logic             sysref_in,
  input  logic             status_clr,
  output logic             lmfc_strobe,
  output logic             lmfc_valid,
  output logic             sysref_seen,
  output logic             sysref_misaligned
);
  import mfa_pkg::*;

  logic       rise, restart, realign, ext_mode, zero;
  sref_mode_e mode_cur;

  mfa_edge u_edge (
    .clk       (clk),
    .rst_n     (rst_n),
    .sysref_in (sysref_in),
    .rise      (rise)
  );

  mfa_track u_track (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_sel   (mode_sel),
    .sync_clr   (sync_clr),
    .status_clr (status_clr),
    .rise       (rise),
    .cnt_zero   (zero),
    .mode_cur   (mode_cur),
    .restart    (restart),
    .realign    (realign),
    .ext_mode   (ext_mode),
    .seen       (sysref_seen),
    .misaligned (sysref_misaligned)
  );

  mfa_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .period  (period),
    .restart (restart),
    .realign (realign),
    .zero    (zero)
  );

  assign lmfc_valid  = !ext_mode | sysref_seen;
  assign lmfc_strobe = lmfc_valid & zero;

  // R5
  hold_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_mode && !sysref_seen) |-> !lmfc_strobe);

  // R7
  once_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_cur == MODE_ONCE && sysref_seen) |-> !realign);
endmodule

// File: tb/sim_mfclk_align.sv
module sim_mfclk_align;
  localparam int CW = 5;

  logic          clk = 1'b0;
  logic          rst_n, sync_clr, sysref_in, status_clr;
  logic [1:0]    mode_sel;
  logic [CW-1:0] period;
  logic          lmfc_strobe, lmfc_valid, sysref_seen, sysref_misaligned;
  int            n_chk = 0;
  int            n_fail = 0;
  bit            done = 1'b0;

  always #5 clk = ~clk;

  mfclk_align #(.CNT_W(CW)) u0 (
    .clk (clk), .rst_n (rst_n), .sync_clr (sync_clr), .mode_sel (mode_sel),
    .period (period), .sysref_in (sysref_in), .status_clr (status_clr),
    .lmfc_strobe (lmfc_strobe), .lmfc_valid (lmfc_valid),
    .sysref_seen (sysref_seen), .sysref_misaligned (sysref_misaligned)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic wait_strobe(output int n);
    n = 0;
    do begin cyc(); n++; end while (!lmfc_strobe && n < 200);
  endtask

  task automatic gap(output int n);
    int k = 0;
    while (!lmfc_strobe && k < 200) begin cyc(); k++; end
    wait_strobe(n);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; sync_clr = 0; sysref_in = 0; status_clr = 0;
    mode_sel = 2'd0; period = CW'(8);
    cyc(); cyc();
    check(sysref_seen == 0, "R10 seen", sysref_seen, 0);
    check(sysref_misaligned == 0, "R10 misaligned", sysref_misaligned, 0);
    check(lmfc_valid && lmfc_strobe, "R10 count zero internal", lmfc_strobe, 1);
    rst_n = 1'b1;
  endtask

  task automatic t_internal();
    int n;
    gap(n);
    check(n == 8, "R2 gap period 8", n, 8);
    sysref_in = 1; cyc(); cyc(); cyc(); sysref_in = 0;
    gap(n);
    check(n == 8, "R4 gap after sysref", n, 8);
    check(sysref_seen == 0, "R4 seen stays low", sysref_seen, 0);
    period = CW'(5);
    gap(n); gap(n);
    check(n == 5, "R2 gap period 5", n, 5);
    period = CW'(1);
    cyc(); cyc();
    n = 0;
    for (int i = 0; i < 4; i++) begin cyc(); if (lmfc_strobe) n++; end
    check(n == 4, "R2 period 1 every cycle", n, 4);
    period = CW'(0);
    n = 0;
    for (int i = 0; i < 4; i++) begin cyc(); if (lmfc_strobe) n++; end
    check(n == 4, "R2 period 0 every cycle", n, 4);
    period = CW'(8);
  endtask

  task automatic t_continuous();
    int n, hits;
    mode_sel = 2'd1; cyc();
    check(sysref_seen == 0, "R9 seen cleared on mode change", sysref_seen, 0);
    hits = 0;
    for (int i = 0; i < 12; i++) begin cyc(); if (lmfc_strobe || lmfc_valid) hits++; end
    check(hits == 0, "R5 held off", hits, 0);
    sysref_in = 1;
    wait_strobe(n);
    check(n == 8, "R5 first strobe after edge", n, 8);
    check(sysref_seen == 1, "R5 seen", sysref_seen, 1);
    check(sysref_misaligned == 0, "R1 held level one edge", sysref_misaligned, 0);
    sysref_in = 0; cyc(); cyc(); cyc();
    sysref_in = 1;
    wait_strobe(n);
    check(n == 8, "R6 realigned", n, 8);
    check(sysref_misaligned == 1, "R8 misaligned set", sysref_misaligned, 1);
    sysref_in = 0;
    wait_strobe(n);
    sysref_in = 1; status_clr = 1; cyc();
    sysref_in = 0; status_clr = 0;
    check(sysref_misaligned == 0, "R8 aligned edge and clear", sysref_misaligned, 1'b0);
    wait_strobe(n);
    check(n == 7, "R6 aligned edge keeps phase", n, 7);
  endtask

  task automatic t_oneshot();
    int n;
    mode_sel = 2'd2; cyc();
    check(lmfc_valid == 0, "R9 valid dropped on mode change", lmfc_valid, 0);
    sysref_in = 1;
    wait_strobe(n);
    check(n == 8, "R5 one-shot first strobe", n, 8);
    sysref_in = 0; cyc(); cyc(); cyc();
    sysref_in = 1; status_clr = 1; cyc();
    sysref_in = 0; status_clr = 0;
    check(sysref_misaligned == 1, "R8 set wins over clear", sysref_misaligned, 1);
    wait_strobe(n);
    check(n == 4, "R7 phase kept", n + 1, 5);
    sync_clr = 1; cyc(); sync_clr = 0;
    check(sysref_seen == 0 && lmfc_valid == 0, "R9 sync_clr capture", sysref_seen, 0);
    check(sysref_misaligned == 0, "R9 sync_clr misaligned", sysref_misaligned, 0);
  endtask

  task automatic t_reserved();
    int n;
    mode_sel = 2'd0; cyc();
    check(lmfc_strobe == 1, "R9 counter cleared on mode change", lmfc_strobe, 1);
    mode_sel = 2'd3; cyc();
    check(lmfc_valid == 1, "R3 reserved valid", lmfc_valid, 1);
    sysref_in = 1; cyc(); cyc(); sysref_in = 0;
    check(sysref_seen == 0, "R3 reserved ignores sysref", sysref_seen, 0);
    gap(n);
    check(n == 8, "R3 reserved free run", n, 8);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_internal();
    t_continuous();
    t_oneshot();
    t_reserved();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule